// File: doc/BRIEF.md
# Receive Frame Length Guard

This block sits in an Ethernet receive path and enforces length rules on a byte stream of frames. Each byte arrives on a valid/ready input with start-of-frame and end-of-frame markers. Bytes that fall within the frame's length limit pass straight through to a valid/ready output in the same cycle. When huge-frame mode is off, bytes beyond the programmed maximum are swallowed and the frame is marked as truncated. The output beat that carries the final delivered byte has `out_last` set.

One cycle after the end-of-frame byte is accepted, the block pulses a status strobe. The strobe carries four results:
- an accept/drop verdict;
- a truncated flag;
- a short-frame flag;
- the number of bytes delivered.

Frames under 64 bytes are dropped. When the short-frame option is set, frames of 17 to 63 bytes are accepted instead. The limit, huge mode and short option are captured on the start-of-frame byte and hold for the whole frame.

Back-pressure is transparent. `in_ready` follows `out_ready` on every beat, including beats that are discarded, so a stall downstream stalls the source. A byte counts as taken only on a cycle where `in_valid` and `in_ready` are both high. `out_valid` never depends on `out_ready`.

Top module: `rx_len_guard`

## Requirements
- R1: Every accepted in-frame byte within the limit appears on `out_data` in the same cycle, with `out_valid` high. Bytes past the limit and bytes outside a frame give `out_valid` low.
- R2: With huge mode off, a frame of length L greater than the maximum M delivers exactly M bytes. `out_last` is set on byte M, and the status reports length M with truncated set.
- R3: A frame whose length is exactly M or M-1 is delivered whole. `out_last` is set on its end-of-frame byte and the truncated flag is clear.
- R4: With huge mode on, every byte is delivered and truncated is never set.
- R5: With short accept off, a frame under 64 delivered bytes is dropped with the short flag set. A frame of 64 or more bytes is accepted with the short flag clear.
- R6: With short accept on, frames of 17 to 63 bytes are accepted with the short flag set. Frames of 16 bytes or fewer are dropped.
- R7: Frames of 1 or 2 bytes (start and end on the same byte, or on adjacent bytes) report correct status. The next frame is then handled normally.
- R8: `stat_valid` is high for exactly one cycle. That cycle is the one after the end-of-frame byte is taken.
- R9: The maximum, huge mode and short accept are sampled on the start-of-frame byte. Changes made later in the frame have no effect on it.
- R10: Bytes taken while no frame is open (no start-of-frame marker seen) are consumed, not forwarded, and produce no status.
- R11: While `out_ready` is low, `in_ready` is low and no byte is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte taken when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is first of frame |
| in_eof | input | 1 | Byte is last of frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last delivered byte of frame |
| cfg_max_len | input | 16 | Maximum frame length in bytes |
| cfg_huge | input | 1 | Huge-frame mode: no truncation |
| cfg_short_ok | input | 1 | Accept frames of 17 to 63 bytes |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_accept | output | 1 | Frame accepted (1) or dropped (0) |
| stat_trunc | output | 1 | Frame was truncated |
| stat_short | output | 1 | Delivered length below 64 |
| stat_len | output | 16 | Delivered byte count |

## Verification
The data path has no register, so `out_valid`, `out_data`, `out_last` and `in_ready` are due in the same cycle the input byte is driven. The bench drives each byte on the falling edge and reads these outputs 1 ns later, before the rising edge that takes the byte. The status fields come from one register stage. They are due in the cycle after the end-of-frame byte is taken, so the bench reads them at the next falling edge. It checks again one cycle later that the strobe has dropped. Stalled beats are repeated until taken, and the expected delivery for each byte is computed only from its index in the frame.

// File: rtl/rlg_pkg.sv
package rlg_pkg;
  // Verdict produced at the end of each frame.
  typedef struct packed {
    logic accept;
    logic trunc;
    logic short_f;
  } rlg_verdict_t;

  localparam int unsigned RLG_MIN_LEN   = 64;
  localparam int unsigned RLG_SHORT_MIN = 16;
endpackage

// File: rtl/rlg_track.sv
// Per-frame tracking: frame-open state, received and delivered counts,
// configuration captured on the start byte, and the per-beat keep/cut decision.
module rlg_track #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sof,
  input  logic             eof,
  input  logic [LEN_W-1:0] cfg_max,
  input  logic             cfg_huge,
  input  logic             cfg_sfa,
  output logic             active,
  output logic             keep,
  output logic             last,
  output logic             done,
  output logic [LEN_W-1:0] dlv_next,
  output logic             trunc_next,
  output logic             sfa_act,
  output logic             busy_q,
  output logic [LEN_W-1:0] max_q,
  output logic             huge_q
);
  localparam int unsigned CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] rx_q, rx_base, rx_n;
  logic [LEN_W-1:0] dlv_q, dlv_base;
  logic             trunc_q, sfa_q;
  logic [LEN_W-1:0] lim;
  logic             huge_act, over, at_lim;

  // Configuration applies from the start byte itself (R9).
  assign lim      = sof ? cfg_max  : max_q;
  assign huge_act = sof ? cfg_huge : huge_q;
  assign sfa_act  = sof ? cfg_sfa  : sfa_q;

  // A start byte always opens a frame; otherwise a frame must be open (R10).
  assign active = sof | busy_q;

  assign rx_base = sof ? '0 : rx_q;
  assign rx_n    = (rx_base == {CNT_W{1'b1}}) ? rx_base : rx_base + 1'b1;

  assign over   = rx_n > {1'b0, lim};
  assign at_lim = rx_n == {1'b0, lim};

  // R1/R2/R4: keep a byte in huge mode or while at or below the limit.
  assign keep = active & (huge_act | ~over);
  // R2/R3: last delivered byte is the end byte or the byte reaching the limit.
  assign last = keep & (eof | (~huge_act & at_lim));
  assign done = active & eof;

  assign dlv_base = sof ? '0 : dlv_q;
  always_comb begin
    dlv_next = dlv_base;
    if (keep && dlv_base != {LEN_W{1'b1}}) dlv_next = dlv_base + 1'b1;
  end
  assign trunc_next = (sof ? 1'b0 : trunc_q) | (active & ~huge_act & over);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rx_q    <= '0;
      dlv_q   <= '0;
      trunc_q <= 1'b0;
      max_q   <= '0;
      huge_q  <= 1'b0;
      sfa_q   <= 1'b0;
    end else if (fire && active) begin
      busy_q  <= ~eof;
      rx_q    <= rx_n;
      dlv_q   <= dlv_next;
      trunc_q <= trunc_next;
      if (sof) begin
        max_q  <= cfg_max;
        huge_q <= cfg_huge;
        sfa_q  <= cfg_sfa;
      end
    end
  end
endmodule

// File: rtl/rlg_judge.sv
// End-of-frame verdict from delivered length and options (R5, R6).
module rlg_judge
  import rlg_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_LEN   = RLG_MIN_LEN,
  parameter int unsigned SHORT_MIN = RLG_SHORT_MIN
) (
  input  logic [LEN_W-1:0] dlv,
  input  logic             trunc,
  input  logic             sfa,
  output rlg_verdict_t     verdict
);
  logic is_short, win_ok;

  assign is_short = dlv < LEN_W'(MIN_LEN);

  generate
    if (SHORT_MIN + 1 < MIN_LEN) begin : g_window
      // Short window exists: lengths above SHORT_MIN may be accepted.
      assign win_ok = sfa & (dlv > LEN_W'(SHORT_MIN));
    end else begin : g_no_window
      logic unused_sfa;
      assign unused_sfa = sfa;
      assign win_ok     = 1'b0;
    end
  endgenerate

  always_comb begin
    verdict.short_f = is_short;
    verdict.trunc   = trunc;
    verdict.accept  = ~is_short | win_ok;
  end
endmodule

// File: rtl/rlg_status.sv
// One-cycle status strobe registered on the end-of-frame beat (R8).
module rlg_status
  import rlg_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  rlg_verdict_t     verdict,
  input  logic [LEN_W-1:0] dlv,
  output logic             stat_valid,
  output logic             stat_accept,
  output logic             stat_trunc,
  output logic             stat_short,
  output logic [LEN_W-1:0] stat_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid  <= 1'b0;
      stat_accept <= 1'b0;
      stat_trunc  <= 1'b0;
      stat_short  <= 1'b0;
      stat_len    <= '0;
    end else begin
      stat_valid <= capture;
      if (capture) begin
        stat_accept <= verdict.accept;
        stat_trunc  <= verdict.trunc;
        stat_short  <= verdict.short_f;
        stat_len    <= dlv;
      end
    end
  end
endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard
  import rlg_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_huge,
  input  logic              cfg_short_ok,
  output logic              stat_valid,
  output logic              stat_accept,
  output logic              stat_trunc,
  output logic              stat_short,
  output logic [LEN_W-1:0]  stat_len
);
  logic             fire, active, keep, last, done, trunc_next, sfa_act;
  logic             busy_q, huge_q;
  logic [LEN_W-1:0] dlv_next, max_q;
  rlg_verdict_t     verdict;

  // R11: discarded beats wait for downstream as well.
  assign in_ready = out_ready;
  assign fire     = in_valid & in_ready;

  rlg_track #(.LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sof(in_sof), .eof(in_eof),
    .cfg_max(cfg_max_len), .cfg_huge(cfg_huge), .cfg_sfa(cfg_short_ok),
    .active(active), .keep(keep), .last(last), .done(done),
    .dlv_next(dlv_next), .trunc_next(trunc_next), .sfa_act(sfa_act),
    .busy_q(busy_q), .max_q(max_q), .huge_q(huge_q)
  );

  rlg_judge #(.LEN_W(LEN_W)) u_judge (
    .dlv(dlv_next), .trunc(trunc_next), .sfa(sfa_act), .verdict(verdict)
  );

  rlg_status #(.LEN_W(LEN_W)) u_status (
    .clk(clk), .rst_n(rst_n), .capture(fire & done), .verdict(verdict),
    .dlv(dlv_next), .stat_valid(stat_valid), .stat_accept(stat_accept),
    .stat_trunc(stat_trunc), .stat_short(stat_short), .stat_len(stat_len)
  );

  // R1: same-cycle pass-through of kept bytes.
  assign out_valid = in_valid & keep;
  assign out_data  = in_data;
  assign out_last  = last;

  logic unused_active;
  assign unused_active = active;
endmodule

// File: rtl/rlg_chk.sv
module rlg_chk #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned SHORT_MIN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic             in_eof,
  input logic             out_valid,
  input logic             out_last,
  input logic             stat_valid,
  input logic             stat_accept,
  input logic             stat_trunc,
  input logic             stat_short,
  input logic [LEN_W-1:0] stat_len,
  input logic             busy_q,
  input logic [LEN_W-1:0] max_q,
  input logic             huge_q
);
  a_r1_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  a_r8_status_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_ready && in_eof && (in_sof || busy_q)));

  a_r11_stall_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !stat_valid);

  a_r2_trunc_len: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_trunc) |-> (stat_len == max_q));

  a_r4_huge_no_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && huge_q) |-> !stat_trunc);

  a_r5_long_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_short) |-> stat_accept);

  a_r6_runt_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_len <= LEN_W'(SHORT_MIN)) |-> !stat_accept);

  a_r3_cut_last_only_limited: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && !in_eof) |-> (busy_q || in_sof) && !huge_q);
endmodule

bind rx_len_guard rlg_chk #(.LEN_W(LEN_W)) u_rlg_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid), .out_last(out_last),
  .stat_valid(stat_valid), .stat_accept(stat_accept), .stat_trunc(stat_trunc),
  .stat_short(stat_short), .stat_len(stat_len), .busy_q(busy_q),
  .max_q(max_q), .huge_q(huge_q)
);

// File: tb/tb_rx_len_guard.sv
module tb_rx_len_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;
  logic [15:0] cfg_max_len;
  logic        cfg_huge, cfg_short_ok;
  logic        stat_valid, stat_accept, stat_trunc, stat_short;
  logic [15:0] stat_len;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  rx_len_guard dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .cfg_max_len(cfg_max_len), .cfg_huge(cfg_huge),
    .cfg_short_ok(cfg_short_ok), .stat_valid(stat_valid),
    .stat_accept(stat_accept), .stat_trunc(stat_trunc),
    .stat_short(stat_short), .stat_len(stat_len)
  );

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic int exp_len(int len, int mx, bit hg);
    return (hg || len <= mx) ? len : mx;
  endfunction

  function automatic bit exp_accept(int d, bit sf);
    return (d >= 64) || (sf && d > 16);
  endfunction

  task automatic send_frame(input string tag, input int len, input int mx,
                            input bit hg, input bit sf, input bit wig, input int bp);
    for (int i = 1; i <= len; i++) begin
      bit stalled;
      do begin
        bit keep, lst;
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (i == 1);
        in_eof   = (i == len);
        in_data  = 8'((i * 7 + len) & 255);
        if (i == 1) begin
          cfg_max_len = 16'(mx); cfg_huge = hg; cfg_short_ok = sf;
        end else if (wig) begin
          cfg_max_len = 16'($urandom); cfg_huge = ~hg; cfg_short_ok = ~sf;
        end
        out_ready = (($urandom % 100) >= bp);
        #1;
        keep = hg || (i <= mx);
        lst  = keep && ((i == len) || (!hg && i == mx));
        if (out_ready) begin
          chk(out_valid == keep, $sformatf("%s R1 out_valid byte %0d", tag, i), out_valid, keep);
          if (keep) begin
            chk(out_data == in_data, $sformatf("%s R1 out_data byte %0d", tag, i), out_data, in_data);
            chk(out_last == lst, $sformatf("%s R2/R3 out_last byte %0d", tag, i), out_last, lst);
          end
        end else begin
          chk(in_ready == 1'b0, $sformatf("%s R11 in_ready during stall", tag), in_ready, 0);
        end
        stalled = !out_ready;
      end while (stalled);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    #1;
    begin
      int  d;
      bit  tr;
      d  = exp_len(len, mx, hg);
      tr = !hg && (len > mx);
      chk(stat_valid == 1'b1, $sformatf("%s R8 status strobe", tag), stat_valid, 1);
      chk(int'(stat_len) == d, $sformatf("%s R2/R4 stat_len", tag), stat_len, d);
      chk(stat_trunc == tr, $sformatf("%s R2/R3/R4 stat_trunc", tag), stat_trunc, tr);
      chk(stat_short == (d < 64), $sformatf("%s R5 stat_short", tag), stat_short, d < 64);
      chk(stat_accept == exp_accept(d, sf), $sformatf("%s R5/R6 stat_accept", tag),
          stat_accept, exp_accept(d, sf));
    end
    @(negedge clk);
    #1;
    chk(stat_valid == 1'b0, $sformatf("%s R8 strobe one cycle", tag), stat_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    out_ready = 1'b1; cfg_max_len = 16'd80; cfg_huge = 1'b0; cfg_short_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "reset out_valid", out_valid, 0);
    chk(stat_valid == 1'b0, "reset stat_valid", stat_valid, 0);
    chk(in_ready == 1'b1, "reset R11 in_ready follows out_ready", in_ready, 1);

    // Directed corner cases.
    send_frame("R3 len=max",      80, 80, 0, 0, 0, 0);
    send_frame("R3 len=max-1",    79, 80, 0, 0, 0, 0);
    send_frame("R2 len=max+1",    81, 80, 0, 0, 0, 0);
    send_frame("R2 long",        200, 80, 0, 0, 0, 0);
    send_frame("R4 huge",        120, 80, 1, 0, 0, 0);
    send_frame("R5 63 drop",      63, 80, 0, 0, 0, 0);
    send_frame("R5 64 keep",      64, 80, 0, 0, 0, 0);
    send_frame("R6 63 keep",      63, 80, 0, 1, 0, 0);
    send_frame("R6 17 keep",      17, 80, 0, 1, 0, 0);
    send_frame("R6 16 drop",      16, 80, 0, 1, 0, 0);
    send_frame("R7 one byte",      1, 80, 0, 1, 0, 0);
    send_frame("R7 two bytes",     2, 80, 0, 1, 0, 0);
    send_frame("R7 after tiny",   70, 80, 0, 0, 0, 20);
    send_frame("R9 cfg wiggle",  100, 90, 0, 0, 1, 0);
    send_frame("R9 cfg wiggle2",  40, 60, 1, 1, 1, 0);

    // R10: stray bytes with no start marker.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 2); in_data = 8'(i); out_ready = 1'b1;
      #1;
      chk(out_valid == 1'b0, "R10 stray byte not forwarded", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    #1;
    chk(stat_valid == 1'b0, "R10 stray bytes give no status", stat_valid, 0);

    // Constrained random frames.
    for (int n = 0; n < 150; n++) begin
      int mx, len;
      mx  = 40 + int'($urandom % 160);
      len = 1 + int'($urandom % (mx + 20));
      send_frame($sformatf("rnd%0d", n), len, mx, bit'($urandom % 4 == 0),
                 bit'($urandom % 2), bit'($urandom % 5 == 0), 30);
      repeat ($urandom % 3) @(negedge clk);
    end

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule